// File: doc/BRIEF.md
# Flash Program and Erase Controller Front End

This block sits between a register-mapped processor bus and a small behavioural flash array. Software uses it to unlock the array, write 16-bit half-words, erase single pages and erase every user page in one pass. While an operation runs, the block holds a busy flag for a fixed number of clock cycles, then writes the result into the array and raises an end-of-operation flag.

The array is modelled inside the block as 16-bit cells, all ones after reset. It holds `USER_PAGES` user pages of `2**PAGE_LOG2` cells each, plus one final information page that mass erase does not clear. The bus has two spaces, selected by `bus_space`. In register space, byte address bits [3:2] select key (0), control (1), erase address (2) or status (3). In flash space, the byte address must be even and bits [IDX_W:1] give the cell index. Read data is registered and appears one cycle after the read request.

Control bits: 0 program enable, 1 page erase, 2 mass erase, 6 start, 7 lock (reads 1 while locked). Status bits: 0 busy, 2 programming error, 4 write-protect error, 5 end of operation.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After reset, control reads 0x80 (locked), status reads 0, and every flash cell reads 0xFFFF.
- R2: Writing 0x45670123 and then 0xCDEF89AB to the key register unlocks the block, so control reads 0x00.
- R3: The first key write that does not match the expected word sets status bit 4 and keeps the block locked until reset, even if correct keys follow.
- R4: While locked, control writes and flash writes are ignored: control stays 0x80, status stays 0 and cells keep their contents.
- R5: With program enable set and the block idle, an even-address flash write to a cell holding 0xFFFF raises busy for PROG_CYC cycles, then stores the data and sets status bit 5.
- R6: A program write to a cell not holding 0xFFFF sets status bit 2 in the next cycle, starts no busy period and leaves the cell unchanged.
- R7: Writing control with page erase and start set raises busy for ERASE_CYC cycles, then sets every cell of the page holding the erase-address register's location to 0xFFFF and sets bit 5. Other pages are untouched.
- R8: Writing control with mass erase and start set erases every user page and leaves the information page unchanged.
- R9: Status bits 2, 4 and 5 clear only when a 1 is written to their own position. Writing 0 leaves them set.
- R10: The start bit reads 1 during an erase and clears when the operation ends. Control writes while busy are ignored.
- R11: Writing control with bit 7 set relocks the block and clears program enable, so later program writes are ignored.
- R12: Flash writes that arrive while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_space | input | 1 | 0 = register space, 1 = flash space |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data; flash writes use bits [15:0] |
| bus_rdata | output | 32 | Registered read data, valid the cycle after the request |

## Verification
The hardest cases to reach are accesses that land inside an operation's busy window: a second program write, or a control write that would relock or restart. The stimulus issues these on the bus cycle that directly follows the launching write, before any status poll, so they hit busy with certainty. The busy length is measured by holding a status read every cycle and counting how many consecutive samples show bit 0 set. The frozen key state is reached from a fresh reset, once with a bad first word and once with a bad second word.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

  localparam logic [31:0] UNLOCK_WORD_A = 32'h4567_0123;
  localparam logic [31:0] UNLOCK_WORD_B = 32'hCDEF_89AB;

  // register offsets (byte address bits [3:2])
  localparam logic [1:0] REG_KEY  = 2'd0;
  localparam logic [1:0] REG_CTRL = 2'd1;
  localparam logic [1:0] REG_ADDR = 2'd2;
  localparam logic [1:0] REG_STAT = 2'd3;

  // control and status bit positions
  localparam int CB_PROG  = 0;
  localparam int CB_PAGE  = 1;
  localparam int CB_MASS  = 2;
  localparam int CB_START = 6;
  localparam int CB_LOCK  = 7;
  localparam int SB_PGERR = 2;
  localparam int SB_WPERR = 4;
  localparam int SB_EOP   = 5;

  typedef enum logic [1:0] {KS_LOCKED, KS_HALF, KS_OPEN, KS_FROZEN} key_state_e;
  typedef enum logic [1:0] {OP_PROG, OP_PAGE, OP_MASS, OP_NONE} op_kind_e;

  function automatic logic cell_blank(input logic [15:0] v);
    return v == 16'hFFFF;
  endfunction

  function automatic int unsigned page_of_index(input int unsigned idx, input int unsigned page_log2);
    return idx >> page_log2;
  endfunction

  // does an erase of the given kind clear cell idx
  function automatic logic erase_covers(input op_kind_e kind, input int unsigned idx,
                                        input int unsigned page, input int unsigned page_log2,
                                        input int unsigned user_cells);
    case (kind)
      OP_MASS: return idx < user_cells;
      OP_PAGE: return page_of_index(idx, page_log2) == page;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/flash_pe_keyseq.sv
module flash_pe_keyseq
  import flash_pe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic [31:0] key_val,
  input  logic        relock,
  output logic        unlocked,
  output logic        key_fail
);
  key_state_e st;

  always_comb begin
    key_fail = key_wr && ((st == KS_LOCKED && key_val != UNLOCK_WORD_A) ||
                          (st == KS_HALF   && key_val != UNLOCK_WORD_B));
    unlocked = (st == KS_OPEN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= KS_LOCKED;
    else begin
      case (st)
        KS_LOCKED: if (key_wr) st <= (key_val == UNLOCK_WORD_A) ? KS_HALF : KS_FROZEN;
        KS_HALF:   if (key_wr) st <= (key_val == UNLOCK_WORD_B) ? KS_OPEN : KS_FROZEN;
        KS_OPEN:   if (relock) st <= KS_LOCKED;
        default:   st <= st;
      endcase
    end
  end
endmodule

// File: rtl/flash_pe_timer.sv
module flash_pe_timer
  import flash_pe_pkg::*;
#(
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 12
)(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     launch,
  input  op_kind_e kind_in,
  output logic     busy,
  output logic     done,
  output op_kind_e kind_q
);
  localparam int CNT_W = $clog2(((PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC) + 1);
  localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYC - 1);

  logic [CNT_W-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      kind_q <= OP_NONE;
    end else if (launch) begin
      busy   <= 1'b1;
      cnt    <= (kind_in == OP_PROG) ? PROG_LOAD : ERASE_LOAD;
      kind_q <= kind_in;
    end else if (done) begin
      busy   <= 1'b0;
      kind_q <= OP_NONE;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/flash_pe_array.sv
module flash_pe_array
  import flash_pe_pkg::*;
#(
  parameter int PAGE_LOG2  = 3,
  parameter int USER_PAGES = 7,
  parameter int DEPTH      = 64,
  parameter int IDX_W      = 6
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [15:0]      wr_data,
  input  logic             erase_en,
  input  op_kind_e         erase_kind,
  input  logic [31:0]      erase_page,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [15:0]      rd_data,
  input  logic [IDX_W-1:0] chk_idx,
  output logic [15:0]      chk_data
);
  localparam int USER_CELLS = USER_PAGES << PAGE_LOG2;

  logic [15:0] cells [DEPTH];

  always_comb begin
    rd_data  = (32'(rd_idx)  < DEPTH) ? cells[rd_idx]  : 16'hFFFF;
    chk_data = (32'(chk_idx) < DEPTH) ? cells[chk_idx] : 16'hFFFF;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n)
        cells[i] <= 16'hFFFF;
      else if (wr_en && 32'(wr_idx) == i)
        cells[i] <= wr_data;
      else if (erase_en && erase_covers(erase_kind, i, erase_page, PAGE_LOG2, USER_CELLS))
        cells[i] <= 16'hFFFF;
    end
  end
endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
  import flash_pe_pkg::*;
#(
  parameter  int USER_PAGES = 7,
  parameter  int PAGE_LOG2  = 3,
  parameter  int PROG_CYC   = 4,
  parameter  int ERASE_CYC  = 12,
  localparam int PAGE_CELLS = 1 << PAGE_LOG2,
  localparam int DEPTH      = (USER_PAGES + 1) * PAGE_CELLS,
  localparam int IDX_W      = $clog2(DEPTH),
  localparam int ADDR_W     = (IDX_W + 1 > 4) ? IDX_W + 1 : 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_space,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  // named internal events
  logic unlocked, key_fail, busy, op_done, op_launch;
  logic prog_try, prog_reject, prog_accept, erase_launch, launch_is_prog;
  logic reg_wr, fl_wr, ctrl_hit, ctrl_wr_ok, relock, in_range;
  op_kind_e launch_kind, run_kind;

  logic pg_q, per_q, mer_q, start_q;
  logic pgerr_q, wperr_q, eop_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  prog_idx_q, bus_idx;
  logic [15:0]       prog_data_q, rd_cell, chk_cell;
  logic [1:0]        reg_off;
  logic [7:0]        ctrl_view;
  logic [31:0]       reg_view, erase_page;

  always_comb begin
    reg_wr   = bus_valid && bus_write && !bus_space;
    fl_wr    = bus_valid && bus_write &&  bus_space;
    reg_off  = bus_addr[3:2];
    bus_idx  = bus_addr[IDX_W:1];
    in_range = 32'(bus_idx) < DEPTH;

    ctrl_hit     = reg_wr && reg_off == REG_CTRL;
    ctrl_wr_ok   = ctrl_hit && unlocked && !busy;
    relock       = ctrl_wr_ok && bus_wdata[CB_LOCK];
    erase_launch = ctrl_wr_ok && !bus_wdata[CB_LOCK] && bus_wdata[CB_START] &&
                   (bus_wdata[CB_PAGE] || bus_wdata[CB_MASS]);

    prog_try    = fl_wr && unlocked && pg_q && !busy && !bus_addr[0] && in_range;
    prog_reject = prog_try && !cell_blank(chk_cell);
    prog_accept = prog_try &&  cell_blank(chk_cell);

    op_launch      = prog_accept || erase_launch;
    launch_kind    = prog_accept ? OP_PROG : (bus_wdata[CB_PAGE] ? OP_PAGE : OP_MASS);
    launch_is_prog = launch_kind == OP_PROG;
    erase_page     = page_of_index(32'(addr_q[IDX_W:1]), PAGE_LOG2);
  end

  flash_pe_keyseq u_keys (
    .clk(clk), .rst_n(rst_n),
    .key_wr(reg_wr && reg_off == REG_KEY), .key_val(bus_wdata),
    .relock(relock), .unlocked(unlocked), .key_fail(key_fail)
  );

  flash_pe_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .launch(op_launch), .kind_in(launch_kind),
    .busy(busy), .done(op_done), .kind_q(run_kind)
  );

  flash_pe_array #(.PAGE_LOG2(PAGE_LOG2), .USER_PAGES(USER_PAGES), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(op_done && run_kind == OP_PROG), .wr_idx(prog_idx_q), .wr_data(prog_data_q),
    .erase_en(op_done && run_kind != OP_PROG), .erase_kind(run_kind), .erase_page(erase_page),
    .rd_idx(bus_idx), .rd_data(rd_cell), .chk_idx(bus_idx), .chk_data(chk_cell)
  );

  // control register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {pg_q, per_q, mer_q, start_q} <= '0;
    end else begin
      if (op_done) start_q <= 1'b0;
      if (ctrl_wr_ok) begin
        if (bus_wdata[CB_LOCK]) begin
          {pg_q, per_q, mer_q, start_q} <= '0;
        end else begin
          pg_q    <= bus_wdata[CB_PROG];
          per_q   <= bus_wdata[CB_PAGE];
          mer_q   <= bus_wdata[CB_MASS];
          start_q <= erase_launch;
        end
      end
    end
  end

  // erase address and latched program target
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q      <= '0;
      prog_idx_q  <= '0;
      prog_data_q <= '0;
    end else begin
      if (reg_wr && reg_off == REG_ADDR && unlocked && !busy) addr_q <= bus_wdata[ADDR_W-1:0];
      if (prog_accept) begin
        prog_idx_q  <= bus_idx;
        prog_data_q <= bus_wdata[15:0];
      end
    end
  end

  // sticky status flags, cleared by writing one; a new event wins
  logic stat_clr;
  assign stat_clr = reg_wr && reg_off == REG_STAT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {pgerr_q, wperr_q, eop_q} <= '0;
    end else begin
      pgerr_q <= prog_reject || (pgerr_q && !(stat_clr && bus_wdata[SB_PGERR]));
      wperr_q <= key_fail    || (wperr_q && !(stat_clr && bus_wdata[SB_WPERR]));
      eop_q   <= op_done     || (eop_q   && !(stat_clr && bus_wdata[SB_EOP]));
    end
  end

  always_comb begin
    ctrl_view = {!unlocked, start_q, 3'b000, mer_q, per_q, pg_q};
    case (reg_off)
      REG_CTRL: reg_view = {24'h0, ctrl_view};
      REG_ADDR: reg_view = 32'(addr_q);
      REG_STAT: reg_view = {26'h0, eop_q, wperr_q, 1'b0, pgerr_q, 1'b0, busy};
      default:  reg_view = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_valid && !bus_write) bus_rdata <= bus_space ? {16'h0, rd_cell} : reg_view;
  end
endmodule

// File: rtl/flash_pe_ctrl_chk.sv
module flash_pe_ctrl_chk #(
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 12
)(
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       op_launch,
  input logic       launch_is_prog,
  input logic       op_done,
  input logic       prog_reject,
  input logic       key_fail,
  input logic       unlocked,
  input logic       pgerr_q,
  input logic       wperr_q,
  input logic       eop_q,
  input logic       start_q,
  input logic       ctrl_hit,
  input logic [7:0] ctrl_view
);
  logic [15:0] busy_run;
  logic        prog_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_run <= '0;
      prog_run <= 1'b0;
    end else begin
      busy_run <= busy ? busy_run + 16'd1 : 16'd0;
      if (op_launch) prog_run <= launch_is_prog;
    end
  end

  // R5 R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_run == (prog_run ? 16'(PROG_CYC) : 16'(ERASE_CYC)));

  // R5
  done_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> eop_q && !busy);

  // R6
  reject_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_reject |=> pgerr_q && !busy);

  // R4
  locked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> !op_launch);

  // R3
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_fail |=> !unlocked && wperr_q);

  // R10
  busy_ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !op_done && ctrl_hit |=> $stable(ctrl_view));

  // R10
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !start_q);
endmodule

bind flash_pe_ctrl flash_pe_ctrl_chk #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .op_launch(op_launch),
  .launch_is_prog(launch_is_prog), .op_done(op_done), .prog_reject(prog_reject),
  .key_fail(key_fail), .unlocked(unlocked), .pgerr_q(pgerr_q), .wperr_q(wperr_q),
  .eop_q(eop_q), .start_q(start_q), .ctrl_hit(ctrl_hit), .ctrl_view(ctrl_view)
);

// File: tb/test_flash_pe_ctrl.sv
module test_flash_pe_ctrl;
  localparam int AW = 7;
  localparam int OP_WR = 0, OP_WF = 1, OP_RR = 2, OP_RF = 3, OP_ID = 4;
  localparam int A_KEY = 0, A_CTRL = 4, A_ADDR = 8, A_STAT = 12;
  localparam logic [31:0] KA = 32'h4567_0123, KB = 32'hCDEF_89AB;

  function automatic logic [79:0] mk(input int op, input int rq, input int ad,
                                     input logic [31:0] d, input logic [31:0] e);
    return {4'(op), 4'(rq), 8'(ad), d, e};
  endfunction

  localparam int NV = 63;
  localparam logic [79:0] VEC [NV] = '{
    mk(OP_RR, 1, A_CTRL, 0, 32'h80),        // R1 locked at reset
    mk(OP_RR, 1, A_STAT, 0, 32'h00),        // R1
    mk(OP_RF, 1, 8'h10, 0, 32'hFFFF),       // R1
    mk(OP_WR, 4, A_CTRL, 32'h01, 0),        // R4 program enable while locked
    mk(OP_WF, 4, 8'h10, 32'h1234, 0),       // R4
    mk(OP_RF, 4, 8'h10, 0, 32'hFFFF),       // R4
    mk(OP_RR, 4, A_CTRL, 0, 32'h80),        // R4
    mk(OP_RR, 4, A_STAT, 0, 32'h00),        // R4
    mk(OP_WR, 2, A_KEY, KA, 0),             // R2
    mk(OP_WR, 2, A_KEY, KB, 0),             // R2
    mk(OP_RR, 2, A_CTRL, 0, 32'h00),        // R2
    mk(OP_WR, 5, A_CTRL, 32'h01, 0),        // R5
    mk(OP_WF, 5, 8'h10, 32'h1234, 0),       // R5
    mk(OP_RR, 5, A_STAT, 0, 32'h01),        // R5 busy
    mk(OP_ID, 5, 0, 0, 0),
    mk(OP_RR, 5, A_STAT, 0, 32'h20),        // R5 end of operation
    mk(OP_RF, 5, 8'h10, 0, 32'h1234),       // R5
    mk(OP_WF, 6, 8'h10, 32'h5678, 0),       // R6 not blank
    mk(OP_RR, 6, A_STAT, 0, 32'h24),        // R6
    mk(OP_RF, 6, 8'h10, 0, 32'h1234),       // R6
    mk(OP_WR, 9, A_STAT, 32'h00, 0),        // R9 zero write
    mk(OP_RR, 9, A_STAT, 0, 32'h24),        // R9
    mk(OP_WR, 9, A_STAT, 32'h04, 0),        // R9
    mk(OP_RR, 9, A_STAT, 0, 32'h20),        // R9
    mk(OP_WR, 9, A_STAT, 32'h20, 0),        // R9
    mk(OP_RR, 9, A_STAT, 0, 32'h00),        // R9
    mk(OP_WF, 8, 8'h72, 32'hABCD, 0),       // R8 information page cell
    mk(OP_ID, 8, 0, 0, 0),
    mk(OP_WF, 7, 8'h30, 32'h1111, 0),       // R7 page 3 first cell
    mk(OP_ID, 7, 0, 0, 0),
    mk(OP_WF, 7, 8'h3E, 32'h2222, 0),       // R7 page 3 last cell
    mk(OP_ID, 7, 0, 0, 0),
    mk(OP_WF, 7, 8'h40, 32'h3333, 0),       // R7 page 4 first cell
    mk(OP_ID, 7, 0, 0, 0),
    mk(OP_WR, 7, A_CTRL, 32'h00, 0),        // R7
    mk(OP_WR, 7, A_ADDR, 32'h34, 0),        // R7
    mk(OP_RR, 7, A_ADDR, 0, 32'h34),        // R7
    mk(OP_WR, 7, A_CTRL, 32'h42, 0),        // R7 page erase + start
    mk(OP_RR, 10, A_CTRL, 0, 32'h42),       // R10 start visible
    mk(OP_WR, 10, A_CTRL, 32'h80, 0),       // R10 relock while busy
    mk(OP_RR, 10, A_CTRL, 0, 32'h42),       // R10
    mk(OP_ID, 7, 0, 0, 0),
    mk(OP_RR, 10, A_CTRL, 0, 32'h02),       // R10 start cleared
    mk(OP_RF, 7, 8'h30, 0, 32'hFFFF),       // R7
    mk(OP_RF, 7, 8'h3E, 0, 32'hFFFF),       // R7
    mk(OP_RF, 7, 8'h40, 0, 32'h3333),       // R7 neighbour page
    mk(OP_RR, 7, A_STAT, 0, 32'h20),        // R7
    mk(OP_WR, 12, A_CTRL, 32'h01, 0),       // R12
    mk(OP_WF, 12, 8'h50, 32'h4444, 0),      // R12
    mk(OP_WF, 12, 8'h52, 32'h5555, 0),      // R12 lands in busy
    mk(OP_ID, 12, 0, 0, 0),
    mk(OP_RF, 12, 8'h50, 0, 32'h4444),      // R12
    mk(OP_RF, 12, 8'h52, 0, 32'hFFFF),      // R12
    mk(OP_WR, 8, A_CTRL, 32'h00, 0),        // R8
    mk(OP_WR, 8, A_CTRL, 32'h44, 0),        // R8 mass erase + start
    mk(OP_ID, 8, 0, 0, 0),
    mk(OP_RF, 8, 8'h10, 0, 32'hFFFF),       // R8
    mk(OP_RF, 8, 8'h50, 0, 32'hFFFF),       // R8
    mk(OP_RF, 8, 8'h72, 0, 32'hABCD),       // R8 information page kept
    mk(OP_WR, 11, A_CTRL, 32'h80, 0),       // R11 relock
    mk(OP_RR, 11, A_CTRL, 0, 32'h80),       // R11
    mk(OP_WR, 11, A_CTRL, 32'h01, 0),       // R11 ignored
    mk(OP_RR, 11, A_CTRL, 0, 32'h80)        // R11
  };

  logic clk = 1'b0;
  logic rst_n;
  logic bus_valid, bus_write, bus_space;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  flash_pe_ctrl i_flash_pe_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_space(bus_space), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic drive_idle();
    bus_valid = 1'b0; bus_write = 1'b0; bus_space = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic check(input int rq, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d %s: got %h expected %h", rq, what, got, exp);
    end
  endtask

  task automatic bus_wr(input logic sp, input logic [7:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_space = sp; bus_addr = a[AW-1:0]; bus_wdata = d;
    @(negedge clk);
    drive_idle();
  endtask

  task automatic bus_rd(input logic sp, input logic [7:0] a, output logic [31:0] q);
    bus_valid = 1'b1; bus_write = 1'b0; bus_space = sp; bus_addr = a[AW-1:0];
    @(negedge clk);
    q = bus_rdata;
    drive_idle();
  endtask

  task automatic wait_idle(input int rq);
    logic [31:0] q;
    int k;
    for (k = 0; k < 200; k++) begin
      bus_rd(1'b0, 8'(A_STAT), q);
      if (!q[0]) break;
    end
    if (k == 200) check(rq, "busy never dropped", 32'd1, 32'd0);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    bus_valid = 1'b1; bus_write = 1'b0; bus_space = 1'b0; bus_addr = 7'(A_STAT);
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (bus_rdata[0]) n++;
      else break;
    end
    drive_idle();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive_idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] q;
    int n;
    do_reset();

    for (int i = 0; i < NV; i++) begin
      int op, rq;
      logic [7:0] ad;
      logic [31:0] d, e;
      {op, rq, ad, d, e} = {28'h0, VEC[i][79:76], 28'h0, VEC[i][75:72], VEC[i][71:0]};
      case (op)
        OP_WR: bus_wr(1'b0, ad, d);
        OP_WF: bus_wr(1'b1, ad, d);
        OP_RR: begin bus_rd(1'b0, ad, q); check(rq, $sformatf("vector %0d reg read", i), q, e); end
        OP_RF: begin bus_rd(1'b1, ad, q); check(rq, $sformatf("vector %0d cell read", i), q, e); end
        default: wait_idle(rq);
      endcase
    end

    // R1: reset restores locked state and blank array
    do_reset();
    bus_rd(1'b0, 8'(A_CTRL), q); check(1, "ctrl after reset", q, 32'h80);
    bus_rd(1'b0, 8'(A_STAT), q); check(1, "status after reset", q, 32'h00);
    bus_rd(1'b1, 8'h72, q);      check(1, "info cell after reset", q, 32'hFFFF);

    // R5 R7: busy window lengths
    bus_wr(1'b0, 8'(A_KEY), KA);
    bus_wr(1'b0, 8'(A_KEY), KB);
    bus_wr(1'b0, 8'(A_CTRL), 32'h01);
    bus_wr(1'b1, 8'h20, 32'h0F0F);
    busy_len(n); check(5, "program busy cycles", 32'(n), 32'd4);
    bus_rd(1'b1, 8'h20, q); check(5, "programmed cell", q, 32'h0F0F);
    bus_wr(1'b0, 8'(A_ADDR), 32'h20);
    bus_wr(1'b0, 8'(A_CTRL), 32'h42);
    busy_len(n); check(7, "erase busy cycles", 32'(n), 32'd12);
    bus_rd(1'b1, 8'h20, q); check(7, "erased cell", q, 32'hFFFF);

    // R3: bad first key freezes, write-protect flag set
    do_reset();
    bus_wr(1'b0, 8'(A_KEY), 32'h1111_1111);
    bus_rd(1'b0, 8'(A_STAT), q); check(3, "wp error after bad key", q, 32'h10);
    bus_wr(1'b0, 8'(A_KEY), KA);
    bus_wr(1'b0, 8'(A_KEY), KB);
    bus_rd(1'b0, 8'(A_CTRL), q); check(3, "still locked after good keys", q, 32'h80);
    bus_wr(1'b0, 8'(A_STAT), 32'h10);
    bus_rd(1'b0, 8'(A_STAT), q); check(9, "wp error cleared by one", q, 32'h00);

    // R3: bad second key
    do_reset();
    bus_wr(1'b0, 8'(A_KEY), KA);
    bus_wr(1'b0, 8'(A_KEY), KA);
    bus_rd(1'b0, 8'(A_STAT), q); check(3, "wp error after bad second key", q, 32'h10);
    bus_wr(1'b0, 8'(A_KEY), KA);
    bus_wr(1'b0, 8'(A_KEY), KB);
    bus_rd(1'b0, 8'(A_CTRL), q); check(3, "frozen until reset", q, 32'h80);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule